// File: doc/BRIEF.md
# Sixteen-Bit Four-Unit Arithmetic Logic Unit

This block is the datapath ALU of a small 16-bit processor. It takes two 16-bit operands and a 5-bit function code. Four sub-units work on the operands in parallel: an adder/subtractor, a comparator, a bitwise Boolean unit and a barrel shifter. The two top bits of the function code choose which sub-unit's value is kept. The chosen value is captured in an output register on the next rising clock edge.

The comparator has no subtractor of its own. It reads the zero, negative, overflow and carry-out flags that the adder/subtractor produces while it computes A minus B. The Boolean unit is a per-bit four-entry lookup. The entry for both inputs low is tied to zero, and the other three entries come from the low three function bits. The shifter has only left-shift stages (1, 2, 4 and 8 places). A right shift mirrors the operand, shifts it left and mirrors the result back.

Top module: `alu16_core`

## Requirements
- R1: While rst_n is low, result reads 0. Otherwise result shows, one rising edge later, the value of the unit chosen by func[4:3]: 00 arithmetic, 01 compare, 10 Boolean, 11 shift.
- R2: Arithmetic with func[0]=0 gives (op_a + op_b) mod 2^16.
- R3: Arithmetic with func[0]=1 gives op_a + ~op_b + 1 mod 2^16, which is op_a − op_b.
- R4: Compare with func[2:1]=00 gives 1 when op_a equals op_b, and 0 otherwise.
- R5: Compare with func[2:1]=01 gives signed op_a < op_b, taken as N XOR V of op_a − op_b. With func[2:1]=10 it gives signed op_a <= op_b, which is Z OR (N XOR V). Both stay correct when the subtraction overflows.
- R6: Compare with func[2:1]=11 gives unsigned op_a < op_b, the inverse of the bit-15 carry-out of op_a − op_b.
- R7: Every compare result has bits 15:1 at zero and bit 0 at 1 for true. The compare always subtracts, whatever func[0] is.
- R8: The Boolean result bit i is 0 when op_a[i]=op_b[i]=0. It is func[2] when both are 1, func[1] when op_a[i]=0 and op_b[i]=1, and func[0] when op_a[i]=1 and op_b[i]=0. This gives AND=100, OR=111, XOR=011 and pass-A=101.
- R9: Shift with func[0]=0 shifts op_a left by op_b[3:0] places and fills with zeros. Bits 15:4 of op_b have no effect.
- R10: Shift with func[0]=1 and func[1]=0 shifts op_a right by op_b[3:0] places and fills with zeros.
- R11: Shift with func[0]=1 and func[1]=1 shifts right and fills with the original op_a[15]. With func[0]=0, func[1] has no effect.
- R12: func[2] has no effect on the shift unit, and func[2:1] has no effect on the arithmetic unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset, clears the result |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand; bits 3:0 give the shift amount |
| func | input | 5 | Function code: unit select in 4:3, sub-function in 2:0 |
| result | output | 16 | Registered result of the chosen unit |

## Verification
Some properties are checked on every cycle. The subtractor's difference plus op_b must give back op_a. The carry-out must agree with an unsigned comparison. Compare results must be zero-extended. A Boolean result must never set a bit where both operands are low. A shift by zero must return op_a unchanged. Other things need the bench's sweeps, which cover every function code over corner operands (0, 1, 0x7FFF, 0x8000, 0xFFFF) and random operands: exact sums across wrap-around, signed compares at overflow, full sign fill on arithmetic right shifts, and the code bits that each unit ignores.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'b00,
        UNIT_CMP   = 2'b01,
        UNIT_BOOL  = 2'b10,
        UNIT_SHIFT = 2'b11
    } unit_e;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_LT  = 2'b01,
        CMP_LE  = 2'b10,
        CMP_ULT = 2'b11
    } cmp_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
        logic carry;
    } flags_t;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output flags_t       flags
);
    logic [W:0] carry_chain;

    assign carry_chain[0] = sub;

    // ripple-carry chain, B conditionally inverted per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic b_eff;
        logic p;
        assign b_eff              = b[i] ^ sub;
        assign p                  = a[i] ^ b_eff;
        assign sum[i]             = p ^ carry_chain[i];
        assign carry_chain[i + 1] = (a[i] & b_eff) | (p & carry_chain[i]);
    end

    assign flags.zero  = ~|sum;
    assign flags.neg   = sum[W-1];
    assign flags.ovf   = carry_chain[W] ^ carry_chain[W-1];
    assign flags.carry = carry_chain[W];

endmodule

// File: rtl/alu16_compare.sv
module alu16_compare
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  flags_t       flags,
    input  cmp_e         mode,
    output logic [W-1:0] res
);
    logic lt_signed;
    logic verdict;

    assign lt_signed = flags.neg ^ flags.ovf;

    always_comb begin
        unique case (mode)
            CMP_EQ:  verdict = flags.zero;
            CMP_LT:  verdict = lt_signed;
            CMP_LE:  verdict = flags.zero | lt_signed;
            CMP_ULT: verdict = ~flags.carry;
            default: verdict = 1'b0;
        endcase
    end

    assign res = {{(W-1){1'b0}}, verdict};

endmodule

// File: rtl/alu16_boolean.sv
module alu16_boolean #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   table_code,
    output logic [W-1:0] res
);
    // lookup index {a,b}: 00 -> 0, 01 -> code[1], 10 -> code[0], 11 -> code[2]
    logic [3:0] lut;
    assign lut = {table_code[2], table_code[0], table_code[1], 1'b0};

    for (genvar i = 0; i < W; i++) begin : g_lut
        assign res[i] = lut[{a[i], b[i]}];
    end

endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
    parameter int W  = 16,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] amount,
    input  logic          go_right,
    input  logic          sign_fill,
    output logic [W-1:0]  res
);
    logic [W-1:0]         mirrored_in;
    logic [W-1:0]         mirrored_out;
    logic [SW:0][W-1:0]   stage;
    logic                 fill_bit;

    assign fill_bit = go_right & sign_fill & a[W-1];

    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign mirrored_in[i]  = a[W-1-i];
        assign mirrored_out[i] = stage[SW][W-1-i];
    end

    assign stage[0] = go_right ? mirrored_in : a;

    // left-shift stages by 1, 2, 4, ... each applied or bypassed
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k + 1] = amount[k]
            ? {stage[k][W-1-STEP:0], {STEP{fill_bit}}}
            : stage[k];
    end

    assign res = go_right ? mirrored_out : stage[SW];

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [4:0]   func,
    output logic [W-1:0] result
);
    localparam int SW = $clog2(W);

    typedef struct packed {
        logic [W-1:0] result;
    } state_t;

    state_t state_d, state_q;

    unit_e        unit_sel;
    logic         do_sub;
    logic [W-1:0] sum_w;
    flags_t       flags_w;
    logic [W-1:0] cmp_w;
    logic [W-1:0] bool_w;
    logic [W-1:0] shift_w;

    assign unit_sel = unit_e'(func[4:3]);
    assign do_sub   = func[0] | (unit_sel == UNIT_CMP);

    alu16_addsub #(.W(W)) u_addsub (
        .a     (op_a),
        .b     (op_b),
        .sub   (do_sub),
        .sum   (sum_w),
        .flags (flags_w)
    );

    alu16_compare #(.W(W)) u_compare (
        .flags (flags_w),
        .mode  (cmp_e'(func[2:1])),
        .res   (cmp_w)
    );

    alu16_boolean #(.W(W)) u_boolean (
        .a          (op_a),
        .b          (op_b),
        .table_code (func[2:0]),
        .res        (bool_w)
    );

    alu16_shifter #(.W(W), .SW(SW)) u_shifter (
        .a         (op_a),
        .amount    (op_b[SW-1:0]),
        .go_right  (func[0]),
        .sign_fill (func[1]),
        .res       (shift_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (unit_sel)
            UNIT_ARITH: state_d.result = sum_w;
            UNIT_CMP:   state_d.result = cmp_w;
            UNIT_BOOL:  state_d.result = bool_w;
            UNIT_SHIFT: state_d.result = shift_w;
            default:    state_d.result = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result = state_q.result;

    // checker-side helper: difference plus subtrahend must restore minuend
    logic [W-1:0] restored_a;
    assign restored_a = sum_w + op_b;

    AST_SUB_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
        do_sub |-> (restored_a == op_a));                                   // R3

    AST_ULT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        do_sub |-> (flags_w.carry == (op_a >= op_b)));                      // R6

    AST_CMP_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == UNIT_CMP) |=> (result[W-1:1] == '0));                  // R7

    AST_BOOL_LOW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == UNIT_BOOL) |=> ((result & ~($past(op_a) | $past(op_b))) == '0)); // R8

    AST_SHIFT_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == UNIT_SHIFT && op_b[SW-1:0] == '0) |=> (result == $past(op_a))); // R9

endmodule

// File: tb/alu16_core_tb_top.sv
module alu16_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [4:0]  func = '0;
    logic [15:0] result;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    alu16_core dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_a   (op_a),
        .op_b   (op_b),
        .func   (func),
        .result (result)
    );

    function automatic logic [15:0] expect_of(logic [15:0] a, logic [15:0] b, logic [4:0] fn);
        logic [15:0] r;
        logic [3:0]  amt;
        r   = '0;
        amt = b[3:0];
        case (fn[4:3])
            2'b00: r = fn[0] ? (a - b) : (a + b);
            2'b01: begin
                case (fn[2:1])
                    2'b00: r = {15'd0, a == b};
                    2'b01: r = {15'd0, $signed(a) <  $signed(b)};
                    2'b10: r = {15'd0, $signed(a) <= $signed(b)};
                    default: r = {15'd0, a < b};
                endcase
            end
            2'b10: begin
                for (int i = 0; i < 16; i++) begin
                    if (a[i] && b[i])       r[i] = fn[2];
                    else if (!a[i] && b[i]) r[i] = fn[1];
                    else if (a[i] && !b[i]) r[i] = fn[0];
                    else                    r[i] = 1'b0;
                end
            end
            default: begin
                if (!fn[0])     r = a << amt;
                else if (fn[1]) r = 16'($signed(a) >>> amt);
                else            r = a >> amt;
            end
        endcase
        return r;
    endfunction

    function automatic string tag_of(logic [4:0] fn);
        case (fn[4:3])
            2'b00: return (fn[2:1] != 2'b00) ? "R12" : (fn[0] ? "R3" : "R2");
            2'b01: case (fn[2:1])
                       2'b00: return "R4";
                       2'b11: return "R6";
                       default: return "R5";
                   endcase
            2'b10: return "R8";
            default: begin
                if (fn[2])       return "R12";
                if (!fn[0])      return "R9";
                return fn[1] ? "R11" : "R10";
            end
        endcase
    endfunction

    task automatic apply(logic [15:0] a, logic [15:0] b, logic [4:0] fn);
        logic [15:0] exp_v;
        @(negedge clk);
        op_a = a;
        op_b = b;
        func = fn;
        exp_v = expect_of(a, b, fn);
        @(negedge clk);
        n_checks++;
        if (result !== exp_v) begin
            n_fails++;
            $display("FAIL %s fn=%b a=%h b=%h actual=%h expected=%h (R1 unit select)",
                     tag_of(fn), fn, a, b, result, exp_v);
        end
        if (fn[4:3] == 2'b01) begin
            n_checks++;
            if (result[15:1] !== 15'd0) begin
                n_fails++;
                $display("FAIL R7 fn=%b upper bits actual=%h expected=0000", fn, result);
            end
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] corners [8];
        corners[0] = 16'h0000; corners[1] = 16'h0001;
        corners[2] = 16'h7FFF; corners[3] = 16'h8000;
        corners[4] = 16'hFFFF; corners[5] = 16'h000F;
        corners[6] = 16'h1234; corners[7] = 16'hA5C3;

        op_a = 16'hFFFF; op_b = 16'h0001; func = 5'b00000;
        repeat (3) @(negedge clk);
        n_checks++;
        if (result !== 16'h0000) begin
            n_fails++;
            $display("FAIL R1 reset actual=%h expected=0000", result);
        end
        rst_n = 1'b1;

        // full code sweep over corner operands
        for (int f = 0; f < 32; f++)
            for (int ia = 0; ia < 8; ia++)
                for (int ib = 0; ib < 8; ib++)
                    apply(corners[ia], corners[ib], 5'(f));

        // R9 / R10 / R11: upper bits of the amount operand ignored
        for (int s = 0; s < 16; s++) begin
            apply(16'h8421, 16'hFFF0 | 16'(s), 5'b11000);
            apply(16'h8421, 16'hABC0 | 16'(s), 5'b11001);
            apply(16'h8421, 16'h5550 | 16'(s), 5'b11011);
        end

        // random operands across every code
        for (int k = 0; k < 1500; k++)
            apply(16'($urandom), 16'($urandom), 5'($urandom));

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule